// File: doc/BRIEF.md
# Cascaded Gated Edge Tally

This block keeps a free-running tally of rising edges on a measured input, held as two half-width counters chained in series. The upper half advances only when the lower half rolls over, so together they form one full-width count. The measured input must already be synchronous to the block clock.

Each rising edge of a gate signal takes a coherent snapshot of both halves and forms the difference from the previous snapshot. That difference is the number of measured edges that fell inside one gate period, and it is offered on a valid/ready output. Converting it to a frequency is left to the consumer. `diff_valid` is the new-result flag. It rises when a gate edge produces a result and falls when the consumer accepts with `diff_ready`. While `diff_valid` is high and `diff_ready` is low, `diff_data` stays put, except when another gate edge arrives. The output has no queue, so a later gate edge overwrites a result that has not been taken, and the consumer always sees the newest period. The latest raw snapshot is also visible on `snap_data`.

Top module: `gated_edge_tally`

## Requirements
- R1: While reset is asserted, both counter halves, the stored snapshot and the result register are zero, and `diff_valid` is low.
- R2: The lower half adds one in each cycle where `meas_in` is high and was low in the previous cycle. A level held high counts once. The lower half wraps from all-ones to zero.
- R3: The upper half adds one in exactly those cycles where the lower half wraps. In every other cycle it holds its value.
- R4: On a gate rising edge, `snap_data` becomes {upper, lower}, with the upper half in the high bits. If a measured edge falls in the same cycle, it is counted in the closing period.
- R5: If a lower-half wrap coincides with a gate edge, the snapshot reflects the wrap in both halves. The snapshot equals the true full-width count.
- R6: `diff_data` equals the new snapshot minus the previous snapshot, modulo 2^(2*HALF_W). The first result after reset equals the snapshot itself.
- R7: `diff_valid` rises the cycle after a gate edge. It then holds, with `diff_data` stable, until a cycle where `diff_ready` is high, and falls after that cycle.
- R8: If a gate edge comes while a result is pending, or in the same cycle as the handshake, the result is replaced by the newest difference and `diff_valid` stays high.
- R9: A gate held high takes only one snapshot. `snap_data` and `diff_valid` are unaffected until the gate falls and rises again.
- R10: A result stays correct when the full count wraps past all-ones during the gate period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_in | input | 1 | Measured signal, synchronous to clk |
| gate_in | input | 1 | Gate signal; a rising edge closes a period |
| diff_valid | output | 1 | Result available |
| diff_ready | input | 1 | Consumer accepts the result |
| diff_data | output | 2*HALF_W (32) | Edges counted in the last gate period |
| snap_data | output | 2*HALF_W (32) | Most recent coherent snapshot |

## Verification
The hardest case to reach is a gate edge in the very cycle where a measured edge makes the lower half wrap. From the ports this depends on the exact count and the exact cycle. The bench uses HALF_W=4, so the lower half wraps every 16 edges and the full count every 256. It tracks the expected count arithmetically, feeds edges until the lower nibble reads all-ones, and then raises the measured input and the gate together. This is repeated across many upper-half values, including the full-count wrap. The same small width lets ordinary sweeps cross the full-width rollover inside a gate period.

// File: rtl/tally_pkg.sv
package tally_pkg;
  // number of chained counter halves forming the full-width count
  localparam int unsigned STAGES = 2;
endpackage

// File: rtl/tally_rise.sv
module tally_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/tally_stage.sv
module tally_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    cnt_nxt = cnt_q;
    if (step_i) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tally_capture.sv
module tally_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_i,
  input  logic [W-1:0] count_i,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] delta;

  // modulo subtraction: the register width drops the borrow
  assign delta = count_i - snap_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_o      <= '0;
      out_data_o  <= '0;
      out_valid_o <= 1'b0;
    end else if (take_i) begin
      snap_o      <= count_i;
      out_data_o  <= delta;
      out_valid_o <= 1'b1;
    end else if (out_valid_o && out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/gated_edge_tally.sv
module gated_edge_tally #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  meas_in,
  input  logic                  gate_in,
  output logic                  diff_valid,
  input  logic                  diff_ready,
  output logic [2*HALF_W-1:0]   diff_data,
  output logic [2*HALF_W-1:0]   snap_data
);
  localparam int unsigned STAGES = tally_pkg::STAGES;
  localparam int unsigned CNT_W  = HALF_W * STAGES;

  logic                meas_rise;
  logic                gate_rise;
  logic [STAGES-1:0]   step;
  logic [HALF_W-1:0]   stage_q   [STAGES];
  logic [HALF_W-1:0]   stage_nxt [STAGES];
  logic [CNT_W-1:0]    count_nxt;
  logic [HALF_W-1:0]   lo_cnt;
  logic [HALF_W-1:0]   hi_cnt;

  tally_rise u_meas_rise (.clk(clk), .rst_n(rst_n), .level_i(meas_in), .rise_o(meas_rise));
  tally_rise u_gate_rise (.clk(clk), .rst_n(rst_n), .level_i(gate_in), .rise_o(gate_rise));

  assign step[0] = meas_rise;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    tally_stage #(.W(HALF_W)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step[g]),
      .cnt_q  (stage_q[g]),
      .cnt_nxt(stage_nxt[g])
    );
    // snapshot taken from the post-update values of every half at once
    assign count_nxt[g*HALF_W +: HALF_W] = stage_nxt[g];
    if (g < STAGES - 1) begin : g_carry
      assign step[g+1] = step[g] & (&stage_q[g]);
    end
  end

  assign lo_cnt = stage_q[0];
  assign hi_cnt = stage_q[STAGES-1];

  tally_capture #(.W(CNT_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (gate_rise),
    .count_i    (count_nxt),
    .out_ready_i(diff_ready),
    .out_valid_o(diff_valid),
    .out_data_o (diff_data),
    .snap_o     (snap_data)
  );
endmodule

// File: rtl/tally_checker.sv
module tally_checker #(
  parameter int unsigned HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                meas_in,
  input logic                gate_in,
  input logic [HALF_W-1:0]   lo_cnt,
  input logic [HALF_W-1:0]   hi_cnt,
  input logic [2*HALF_W-1:0] snap_data,
  input logic                diff_valid,
  input logic                diff_ready,
  input logic [2*HALF_W-1:0] diff_data
);
  logic meas_d, gate_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_d <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      meas_d <= meas_in;
      gate_d <= gate_in;
    end
  end

  logic m_edge, g_edge;
  assign m_edge = meas_in & ~meas_d;
  assign g_edge = gate_in & ~gate_d;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (lo_cnt == '0 && hi_cnt == '0 && snap_data == '0 && !diff_valid));

  p_lower_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_edge |=> lo_cnt == HALF_W'($past(lo_cnt) + 1'b1));

  p_lower_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !m_edge |=> $stable(lo_cnt));

  p_upper_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_edge && lo_cnt == '1) |=> hi_cnt == HALF_W'($past(hi_cnt) + 1'b1));

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_edge && lo_cnt == '1) |=> $stable(hi_cnt));

  p_snap_coherent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    g_edge |=> snap_data == {hi_cnt, lo_cnt});

  p_diff_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    g_edge |=> diff_data == (2*HALF_W)'(snap_data - $past(snap_data)));

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    g_edge |=> diff_valid);

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_valid && !diff_ready && !g_edge) |=> (diff_valid && $stable(diff_data)));

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (diff_valid && diff_ready && !g_edge) |=> !diff_valid);

  p_no_gate_no_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !g_edge |=> $stable(snap_data));
endmodule

bind gated_edge_tally tally_checker #(.HALF_W(HALF_W)) u_tally_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .meas_in   (meas_in),
  .gate_in   (gate_in),
  .lo_cnt    (lo_cnt),
  .hi_cnt    (hi_cnt),
  .snap_data (snap_data),
  .diff_valid(diff_valid),
  .diff_ready(diff_ready),
  .diff_data (diff_data)
);

// File: tb/test_gated_edge_tally.sv
module test_gated_edge_tally;
  localparam int unsigned HW = 4;
  localparam int unsigned W  = 2 * HW;
  localparam int         MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         meas_in = 1'b0;
  logic         gate_in = 1'b0;
  logic         diff_ready = 1'b0;
  logic         diff_valid;
  logic [W-1:0] diff_data;
  logic [W-1:0] snap_data;

  gated_edge_tally #(.HALF_W(HW)) i_gated_edge_tally (
    .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .gate_in(gate_in),
    .diff_valid(diff_valid), .diff_ready(diff_ready),
    .diff_data(diff_data), .snap_data(snap_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_tag = "R1";

  // arithmetic model of the requirements
  int           model_cnt = 0;
  logic         prev_s = 1'b0, prev_g = 1'b0;
  logic [W-1:0] e_snap = '0, e_data = '0;
  logic         e_valid = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) actual %0d expected %0d", req, cur_tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic g, input logic r);
    logic cap;
    @(negedge clk);
    meas_in = s; gate_in = g; diff_ready = r;
    @(posedge clk); #1;
    if (s && !prev_s) model_cnt = (model_cnt + 1) % MOD;
    cap = g && !prev_g;
    if (cap) begin
      e_data  = W'(model_cnt) - e_snap;
      e_snap  = W'(model_cnt);
      e_valid = 1'b1;
    end else if (e_valid && r) begin
      e_valid = 1'b0;
    end
    prev_s = s; prev_g = g;
    chk(cap ? "R4" : "R9", int'(snap_data), int'(e_snap));
    chk("R7", int'(diff_valid), int'(e_valid));
    if (e_valid) chk("R6", int'(diff_data), int'(e_data));
  endtask

  task automatic edges(input int n, input logic r);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 1'b0, r);
      cyc(1'b0, 1'b0, r);
    end
  endtask

  task automatic gate_pulse(input logic r);
    cyc(1'b0, 1'b1, r);
    cyc(1'b0, 1'b0, r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_tag = "R1";
    chk("R1", int'(snap_data), 0);
    chk("R1", int'(diff_valid), 0);
    chk("R1", int'(diff_data), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: n edges per period, first result equals the snapshot (R6)
    cur_tag = "R2";
    for (int n = 0; n < 18; n++) begin
      edges(n, 1'b1);
      gate_pulse(1'b1);
    end
    // R2: a level held high counts once
    cyc(1'b1, 1'b0, 1'b1); cyc(1'b1, 1'b0, 1'b1); cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    gate_pulse(1'b1);

    // R3 and R10: long run crossing half and full wraps
    cur_tag = "R3";
    for (int k = 0; k < 14; k++) begin
      edges(23, 1'b1);
      gate_pulse(1'b1);
    end
    cur_tag = "R10";
    edges(250, 1'b1);
    gate_pulse(1'b1);
    edges(255, 1'b0);
    gate_pulse(1'b1);

    // R5: measured edge that wraps the lower half coincides with gate edge
    cur_tag = "R5";
    for (int k = 0; k < 20; k++) begin
      while ((model_cnt % 16) != 15) edges(1, 1'b1);
      edges(k % 3, 1'b1);
      while ((model_cnt % 16) != 15) edges(1, 1'b1);
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b0, 1'b0, 1'b1);
      chk("R5", int'(snap_data), model_cnt);
    end

    // R8: captures while pending, and capture with handshake
    cur_tag = "R8";
    edges(5, 1'b0); gate_pulse(1'b0);
    edges(7, 1'b0); gate_pulse(1'b0);
    chk("R8", int'(diff_data), 7);
    edges(3, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R8", int'(diff_valid), 1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    chk("R7", int'(diff_valid), 0);

    // R9: gate held high takes one snapshot
    cur_tag = "R9";
    cyc(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b1, 1'b1);
      cyc(1'b0, 1'b1, 1'b1);
    end
    chk("R9", int'(diff_valid), 0);
    cyc(1'b0, 1'b0, 1'b1);
    gate_pulse(1'b0);
    chk("R9", int'(diff_data), 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (phase %s) actual timeout expected completion", cur_tag);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule